// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block resolves a 32-bit virtual address into a 34-bit physical address by reading page-table entries from memory. It starts at the table page given by a root page-number input and reads one entry per level. It stops when it finds a leaf entry. A leaf at the lower level maps a 4 KiB page. A leaf at the top level maps a 4 MiB superpage, and the walk ends there after a single read. If the walk finds a bad entry, it reports a page fault instead of an address.

A requester hands in one address through a valid/ready handshake. The block accepts no new request until its response has been taken. The entry reads go out on a simple read port: the request waits for a ready signal, and the data comes back later with its own valid strobe. The virtual address is divided from the top as follows: a 10-bit top-level index in bits 31:22, a 10-bit lower-level index in bits 21:12, and a 12-bit page offset in bits 11:0.

Top module: `ptw_top`

## Requirements
- R1: `req_ready_o` is high only while no walk is active. It drops in the cycle after a request is accepted and stays low until the response handshake completes.
- R2: The first entry read addresses `root_ppn_i * 4096 + top_index * 4`.
- R3: A valid top-level entry with bits 3:1 all zero is a pointer. The next read addresses `entry_ppn * 4096 + lower_index * 4`, where `entry_ppn` is entry bits 31:10.
- R4: A valid lower-level entry with any of bit 1 (read), bit 2 (write) or bit 3 (execute) set is a leaf. The response then has fault low and the address `{entry_ppn, offset}`.
- R5: A valid top-level leaf ends the walk after exactly one read. If entry bits 19:10 are zero, the response is `{entry bits 31:20, vaddr bits 21:0}` with fault low.
- R6: A top-level leaf whose entry bits 19:10 are not zero produces a fault after one read.
- R7: An entry with bit 0 (valid) clear produces a fault at either level. Every faulting response carries an address of zero.
- R8: An entry with write set and read clear produces a fault.
- R9: A pointer entry (valid, bits 3:1 zero) at the lower level produces a fault after two reads.
- R10: `rsp_valid_o`, `rsp_paddr_o` and `rsp_fault_o` hold steady until `rsp_ready_i` is seen. The response is withdrawn in the cycle after the handshake.
- R11: After reset, `req_ready_o` is high and both `rsp_valid_o` and `mem_req_valid_o` are low.
- R12: `mem_req_valid_o` and `mem_req_addr_o` hold steady while `mem_req_ready_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request valid |
| req_ready_o | output | 1 | Walker idle, request can be taken |
| req_vaddr_i | input | 32 | Virtual address to translate |
| root_ppn_i | input | 22 | Page number of the top-level table |
| rsp_valid_o | output | 1 | Translation result valid |
| rsp_ready_i | input | 1 | Requester takes the result |
| rsp_paddr_o | output | 34 | Physical address, zero on a fault |
| rsp_fault_o | output | 1 | Page fault |
| mem_req_valid_o | output | 1 | Entry read request |
| mem_req_ready_i | input | 1 | Memory accepts the read |
| mem_req_addr_o | output | 34 | Byte address of the entry |
| mem_rsp_valid_i | input | 1 | Entry data valid |
| mem_rsp_data_i | input | 32 | Entry data |

## Verification
A wrong level counter or table pointer shows up on the second read. Its address comes out at the wrong table or index one cycle after the first entry returns. It also shows up as a superpage that issues a second read, or a 4 KiB leaf whose address keeps virtual bits in place of the entry's low page number. A corrupted state register shows up within a cycle as a broken handshake: ready is seen together with a pending response, a response drops before it is taken, or a read request moves while it is stalled. A fault decision taken on the wrong level shows up in the response that follows the entry data by one cycle.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W     = 32;
  localparam int OFF_W    = 12;
  localparam int IDX_W    = 10;
  localparam int LEVELS   = 2;
  localparam int PTE_W    = 32;
  localparam int PPN_W    = 22;
  localparam int SW_W     = PTE_W - PPN_W - 4;
  localparam int PA_W     = PPN_W + OFF_W;
  localparam int VPN_W    = LEVELS * IDX_W;
  localparam int LVL_W    = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_LOG  = $clog2(PTE_W / 8);

  typedef struct packed {
    logic [PPN_W-1:0] ppn;
    logic [SW_W-1:0]  sw;
    logic             x;
    logic             w;
    logic             r;
    logic             v;
  } pte_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_RESP
  } walk_st_e;
endpackage

// File: rtl/ptw_pte_check.sv
module ptw_pte_check
  import ptw_pkg::*;
(
  input  pte_t             pte_i,
  input  logic [LVL_W-1:0] lvl_i,
  input  logic [VPN_W-1:0] vpn_i,
  output logic             leaf_o,
  output logic             fault_o,
  output logic [PPN_W-1:0] leaf_ppn_o
);
  logic [PPN_W-1:0] sp_mask;
  logic             misalign;
  logic             bad_perm;
  logic             ptr_at_bottom;

  // bits of the page number replaced by virtual bits at this level
  assign sp_mask = (PPN_W'(1) << (IDX_W * int'(lvl_i))) - PPN_W'(1);

  assign leaf_o        = pte_i.r | pte_i.w | pte_i.x;
  assign misalign      = leaf_o && ((pte_i.ppn & sp_mask) != '0);
  assign bad_perm      = pte_i.w & ~pte_i.r;
  assign ptr_at_bottom = (lvl_i == '0) && !leaf_o;

  assign fault_o    = !pte_i.v || bad_perm || ptr_at_bottom || misalign;
  assign leaf_ppn_o = (pte_i.ppn & ~sp_mask) | (PPN_W'(vpn_i) & sp_mask);
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] tbl_ppn_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic [PA_W-1:0]  addr_o
);
  logic [IDX_W-1:0] idx [LEVELS];

  for (genvar l = 0; l < LEVELS; l++) begin : g_idx
    assign idx[l] = vpn_i[l*IDX_W +: IDX_W];
  end

  assign addr_o = {tbl_ppn_i, {OFF_W{1'b0}}}
                + (PA_W'(idx[lvl_i]) << ENT_LOG);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             req_ready_o,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  input  logic             mem_rsp_valid_i,
  input  logic             pte_leaf_i,
  input  logic             pte_fault_i,
  input  logic [PPN_W-1:0] pte_ppn_i,
  input  logic [PPN_W-1:0] leaf_ppn_i,
  output logic [LVL_W-1:0] lvl_o,
  output logic [PPN_W-1:0] tbl_ppn_o,
  output logic [VPN_W-1:0] vpn_o
);
  walk_st_e         st_q;
  logic [VA_W-1:0]  vaddr_q;
  logic [PPN_W-1:0] tbl_q;
  logic [LVL_W-1:0] lvl_q;
  logic [PA_W-1:0]  pa_q;
  logic             flt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      vaddr_q <= '0;
      tbl_q   <= '0;
      lvl_q   <= '0;
      pa_q    <= '0;
      flt_q   <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          vaddr_q <= req_vaddr_i;
          tbl_q   <= root_ppn_i;
          lvl_q   <= LVL_W'(LEVELS - 1);
          st_q    <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready_i) st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid_i) begin
          if (pte_fault_i) begin
            pa_q  <= '0;
            flt_q <= 1'b1;
            st_q  <= ST_RESP;
          end else if (pte_leaf_i) begin
            pa_q  <= {leaf_ppn_i, vaddr_q[OFF_W-1:0]};
            flt_q <= 1'b0;
            st_q  <= ST_RESP;
          end else begin
            tbl_q <= pte_ppn_i;
            lvl_q <= lvl_q - LVL_W'(1);
            st_q  <= ST_ISSUE;
          end
        end
        ST_RESP: if (rsp_ready_i) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (st_q == ST_IDLE);
  assign mem_req_valid_o = (st_q == ST_ISSUE);
  assign rsp_valid_o     = (st_q == ST_RESP);
  assign rsp_paddr_o     = pa_q;
  assign rsp_fault_o     = flt_q;
  assign lvl_o           = lvl_q;
  assign tbl_ppn_o       = tbl_q;
  assign vpn_o           = vaddr_q[VA_W-1:OFF_W];
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [VA_W-1:0]  req_vaddr_i,
  input  logic [PPN_W-1:0] root_ppn_i,
  output logic             rsp_valid_o,
  input  logic             rsp_ready_i,
  output logic [PA_W-1:0]  rsp_paddr_o,
  output logic             rsp_fault_o,
  output logic             mem_req_valid_o,
  input  logic             mem_req_ready_i,
  output logic [PA_W-1:0]  mem_req_addr_o,
  input  logic             mem_rsp_valid_i,
  input  logic [PTE_W-1:0] mem_rsp_data_i
);
  pte_t             pte;
  logic             pte_leaf;
  logic             pte_fault;
  logic [PPN_W-1:0] leaf_ppn;
  logic [LVL_W-1:0] lvl;
  logic [PPN_W-1:0] tbl_ppn;
  logic [VPN_W-1:0] vpn;
  logic             unused_sw;

  assign pte       = pte_t'(mem_rsp_data_i);
  assign unused_sw = ^pte.sw;

  ptw_ctrl u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_vaddr_i     (req_vaddr_i),
    .root_ppn_i      (root_ppn_i),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .pte_leaf_i      (pte_leaf),
    .pte_fault_i     (pte_fault),
    .pte_ppn_i       (pte.ppn),
    .leaf_ppn_i      (leaf_ppn),
    .lvl_o           (lvl),
    .tbl_ppn_o       (tbl_ppn),
    .vpn_o           (vpn)
  );

  ptw_pte_check u_chk_pte (
    .pte_i      (pte),
    .lvl_i      (lvl),
    .vpn_i      (vpn),
    .leaf_o     (pte_leaf),
    .fault_o    (pte_fault),
    .leaf_ppn_o (leaf_ppn)
  );

  ptw_addr_gen u_addr (
    .tbl_ppn_i (tbl_ppn),
    .vpn_i     (vpn),
    .lvl_i     (lvl),
    .addr_o    (mem_req_addr_o)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker
  import ptw_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_valid_i,
  input logic             req_ready_o,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic [PPN_W-1:0] root_ppn_i,
  input logic             rsp_valid_o,
  input logic             rsp_ready_i,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             rsp_fault_o,
  input logic             mem_req_valid_o,
  input logic             mem_req_ready_i,
  input logic [PA_W-1:0]  mem_req_addr_o,
  input logic             mem_rsp_valid_i,
  input logic [PTE_W-1:0] mem_rsp_data_i
);
  logic [2:0]       rd_cnt;
  logic [2:0]       rsp_cnt;
  logic [VA_W-1:0]  va_c;
  logic [PPN_W-1:0] root_c;
  logic             top_leaf;
  logic             unused_chk;

  assign unused_chk = ^{mem_rsp_data_i[PTE_W-1:PTE_W-(PPN_W-IDX_W)],
                        mem_rsp_data_i[OFF_W-3:4], va_c[VA_W-IDX_W-1:0]};
  assign top_leaf   = mem_rsp_data_i[0] && (mem_rsp_data_i[3:1] != 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_cnt  <= '0;
      rsp_cnt <= '0;
      va_c    <= '0;
      root_c  <= '0;
    end else if (req_valid_i && req_ready_o) begin
      rd_cnt  <= '0;
      rsp_cnt <= '0;
      va_c    <= req_vaddr_i;
      root_c  <= root_ppn_i;
    end else begin
      if (mem_req_valid_o && mem_req_ready_i && rd_cnt != 3'd7) rd_cnt <= rd_cnt + 3'd1;
      if (mem_rsp_valid_i && rsp_cnt != 3'd7) rsp_cnt <= rsp_cnt + 3'd1;
    end
  end

  assert_busy_not_ready_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o || mem_req_valid_o) |-> !req_ready_o);

  assert_first_addr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && rd_cnt == 3'd0) |->
      mem_req_addr_o == {root_c, va_c[VA_W-1:VA_W-IDX_W], 2'b00});

  assert_read_bound_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_cnt <= 3'd2);

  assert_super_misalign_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && rsp_cnt == 3'd0 && top_leaf &&
     mem_rsp_data_i[OFF_W+7:OFF_W-2] != '0) |=> (rsp_valid_o && rsp_fault_o));

  assert_invalid_fault_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_rsp_valid_i && !mem_rsp_data_i[0]) |=>
      (rsp_valid_o && rsp_fault_o && rsp_paddr_o == '0));

  assert_rsp_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=>
      (rsp_valid_o && $stable(rsp_paddr_o) && $stable(rsp_fault_o)));

  assert_mem_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_valid_o && !mem_req_ready_i) |=>
      (mem_req_valid_o && $stable(mem_req_addr_o)));
endmodule

bind ptw_top ptw_checker u_ptw_checker (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .req_valid_i     (req_valid_i),
  .req_ready_o     (req_ready_o),
  .req_vaddr_i     (req_vaddr_i),
  .root_ppn_i      (root_ppn_i),
  .rsp_valid_o     (rsp_valid_o),
  .rsp_ready_i     (rsp_ready_i),
  .rsp_paddr_o     (rsp_paddr_o),
  .rsp_fault_o     (rsp_fault_o),
  .mem_req_valid_o (mem_req_valid_o),
  .mem_req_ready_i (mem_req_ready_i),
  .mem_req_addr_o  (mem_req_addr_o),
  .mem_rsp_valid_i (mem_rsp_valid_i),
  .mem_rsp_data_i  (mem_rsp_data_i)
);

// File: tb/ptw_top_tb_top.sv
module ptw_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_vaddr_i = '0;
  logic [21:0] root_ppn_i = '0;
  logic        rsp_valid_o;
  logic        rsp_ready_i = 1'b0;
  logic [33:0] rsp_paddr_o;
  logic        rsp_fault_o;
  logic        mem_req_valid_o;
  logic        mem_req_ready_i;
  logic [33:0] mem_req_addr_o;
  logic        mem_rsp_valid_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;

  logic        mem_stall = 1'b0;
  int          rd_count = 0;
  logic [33:0] a_prev = '0;
  logic [33:0] a_last = '0;
  logic [31:0] mem_q [logic [33:0]];

  int          n_chk = 0;
  int          n_fail = 0;
  logic [33:0] got_pa;
  logic        got_flt;
  int          got_reads;
  int          rd_start;

  always #5 clk_i = ~clk_i;

  assign mem_req_ready_i = ~mem_stall;

  ptw_top dut_i (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_valid_i     (req_valid_i),
    .req_ready_o     (req_ready_o),
    .req_vaddr_i     (req_vaddr_i),
    .root_ppn_i      (root_ppn_i),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_paddr_o     (rsp_paddr_o),
    .rsp_fault_o     (rsp_fault_o),
    .mem_req_valid_o (mem_req_valid_o),
    .mem_req_ready_i (mem_req_ready_i),
    .mem_req_addr_o  (mem_req_addr_o),
    .mem_rsp_valid_i (mem_rsp_valid_i),
    .mem_rsp_data_i  (mem_rsp_data_i)
  );

  // memory model: one-cycle read latency, absent entries read as zero
  always @(posedge clk_i) begin
    mem_rsp_valid_i <= 1'b0;
    if (mem_req_valid_o && !mem_stall) begin
      mem_rsp_valid_i <= 1'b1;
      mem_rsp_data_i  <= mem_q.exists(mem_req_addr_o) ? mem_q[mem_req_addr_o] : 32'h0;
      rd_count        <= rd_count + 1;
      a_prev          <= a_last;
      a_last          <= mem_req_addr_o;
    end
  end

  function automatic logic [33:0] ent_addr(input logic [21:0] ppn, input logic [9:0] idx);
    return {ppn, 12'h000} + 34'(idx) * 34'd4;
  endfunction

  // flags = {x, w, r, v}
  function automatic logic [31:0] mk_pte(input logic [21:0] ppn, input logic [3:0] flags);
    return {ppn, 6'b000000, flags};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic start_req(input logic [31:0] va);
    rd_start = rd_count;
    @(negedge clk_i);
    req_vaddr_i = va;
    req_valid_i = 1'b1;
    while (!req_ready_o) @(negedge clk_i);
    @(posedge clk_i);
    #1;
    req_valid_i = 1'b0;
    chk("R1 ready low after accept", 64'(req_ready_o), 64'd0);
  endtask

  task automatic finish_rsp(input int hold);
    int n;
    n = 0;
    @(negedge clk_i);
    while (!rsp_valid_o && n < 200) begin
      @(negedge clk_i);
      n++;
    end
    chk("R10 response arrives", 64'(rsp_valid_o), 64'd1);
    got_pa  = rsp_paddr_o;
    got_flt = rsp_fault_o;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk_i);
      chk("R10 response held", 64'({rsp_valid_o, rsp_fault_o, rsp_paddr_o}),
          64'({1'b1, got_flt, got_pa}));
      chk("R1 ready low while response pending", 64'(req_ready_o), 64'd0);
    end
    rsp_ready_i = 1'b1;
    @(posedge clk_i);
    #1;
    rsp_ready_i = 1'b0;
    chk("R10 response withdrawn", 64'(rsp_valid_o), 64'd0);
    chk("R1 ready back after handshake", 64'(req_ready_o), 64'd1);
    got_reads = rd_count - rd_start;
  endtask

  task automatic t_reset;
    chk("R11 ready after reset", 64'(req_ready_o), 64'd1);
    chk("R11 no response after reset", 64'(rsp_valid_o), 64'd0);
    chk("R11 no read after reset", 64'(mem_req_valid_o), 64'd0);
  endtask

  task automatic t_page4k;
    logic [31:0] va = 32'h1234_5678;
    logic [21:0] root = 22'h00100, mid = 22'h00200, leaf = 22'h3ABCD;
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(leaf, 4'b0011);
    start_req(va);
    finish_rsp(3);
    chk("R2 first read address", 64'(a_prev), 64'(ent_addr(root, va[31:22])));
    chk("R3 second read address", 64'(a_last), 64'(ent_addr(mid, va[21:12])));
    chk("R4 4K address", 64'(got_pa), 64'({leaf, va[11:0]}));
    chk("R4 4K no fault", 64'(got_flt), 64'd0);
    chk("R4 two reads", 64'(got_reads), 64'd2);
  endtask

  task automatic t_page4k_exec;
    logic [31:0] va = 32'hFFC0_0ABC;
    logic [21:0] root = 22'h2FFFF, mid = 22'h00001, leaf = 22'h00777;
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(leaf, 4'b1001);
    start_req(va);
    finish_rsp(0);
    chk("R2 first read top index", 64'(a_prev), 64'(ent_addr(root, va[31:22])));
    chk("R4 exec-only leaf address", 64'({got_flt, got_pa}), 64'({1'b0, leaf, va[11:0]}));
  endtask

  task automatic t_super_ok;
    logic [31:0] va = 32'h8765_4321;
    logic [21:0] root = 22'h00040, sp = {12'hABC, 10'h000};
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(sp, 4'b1011);
    start_req(va);
    finish_rsp(1);
    chk("R5 superpage address", 64'(got_pa), 64'({12'hABC, va[21:0]}));
    chk("R5 superpage no fault", 64'(got_flt), 64'd0);
    chk("R5 one read", 64'(got_reads), 64'd1);
  endtask

  task automatic t_super_misaligned;
    logic [31:0] va = 32'h0040_1000;
    logic [21:0] root = 22'h00050, sp = {12'h123, 10'h001};
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(sp, 4'b0011);
    start_req(va);
    finish_rsp(0);
    chk("R6 misaligned superpage fault", 64'(got_flt), 64'd1);
    chk("R6 one read", 64'(got_reads), 64'd1);
    chk("R7 fault address zero", 64'(got_pa), 64'd0);
  endtask

  task automatic t_invalid;
    logic [31:0] va = 32'hDEAD_B000;
    logic [21:0] root = 22'h00060, mid = 22'h00070;
    mem_q.delete();
    root_ppn_i = root;
    start_req(va);
    finish_rsp(0);
    chk("R7 invalid top entry fault", 64'({got_flt, got_pa}), 64'({1'b1, 34'h0}));
    chk("R7 invalid top one read", 64'(got_reads), 64'd1);
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(22'h01234, 4'b1110);
    start_req(va);
    finish_rsp(0);
    chk("R7 invalid lower entry fault", 64'({got_flt, got_pa}), 64'({1'b1, 34'h0}));
  endtask

  task automatic t_write_only;
    logic [31:0] va = 32'h0123_4567;
    logic [21:0] root = 22'h00080, mid = 22'h00090;
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(22'h00ABC, 4'b0101);
    start_req(va);
    finish_rsp(0);
    chk("R8 write without read faults", 64'(got_flt), 64'd1);
    mem_q[ent_addr(root, va[31:22])] = mk_pte({12'h010, 10'h000}, 4'b0101);
    start_req(va);
    finish_rsp(0);
    chk("R8 write-only superpage faults", 64'({got_flt, got_reads[1:0]}), 64'({1'b1, 2'd1}));
  endtask

  task automatic t_pointer_bottom;
    logic [31:0] va = 32'h5555_5555;
    logic [21:0] root = 22'h000A0, mid = 22'h000B0;
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(22'h000C0, 4'b0001);
    start_req(va);
    finish_rsp(0);
    chk("R9 pointer at lower level faults", 64'(got_flt), 64'd1);
    chk("R9 two reads", 64'(got_reads), 64'd2);
  endtask

  task automatic t_mem_stall;
    logic [31:0] va = 32'h2468_ACE0;
    logic [21:0] root = 22'h000D0, mid = 22'h000E0, leaf = 22'h15555;
    logic [33:0] a0;
    mem_q.delete();
    root_ppn_i = root;
    mem_q[ent_addr(root, va[31:22])] = mk_pte(mid, 4'b0001);
    mem_q[ent_addr(mid, va[21:12])]  = mk_pte(leaf, 4'b0111);
    mem_stall = 1'b1;
    start_req(va);
    a0 = ent_addr(root, va[31:22]);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R12 read held while stalled", 64'({mem_req_valid_o, mem_req_addr_o}),
          64'({1'b1, a0}));
    end
    mem_stall = 1'b0;
    finish_rsp(0);
    chk("R12 walk completes after stall", 64'({got_flt, got_pa}), 64'({1'b0, leaf, va[11:0]}));
    chk("R12 no extra reads", 64'(got_reads), 64'd2);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_page4k();
    t_page4k_exec();
    t_super_ok();
    t_super_misaligned();
    t_invalid();
    t_write_only();
    t_pointer_bottom();
    t_mem_stall();
    repeat (2) @(negedge clk_i);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule